// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is the serial slave side of a small sensor-style peripheral. It watches a two-wire bus whose clock and data lines have already been brought into the system clock domain. It recognises bus start, stop and repeated-start conditions. It answers a 7-bit address made of the fixed nibble `0011` followed by three strap inputs, so eight such slaves can share one bus. It keeps a one-byte register pointer that selects one of a bank of 16-bit registers. The register bank lives outside the block and is reached through a pointer output, a read-data input and a write strobe.

Three transfers are supported. A write sends the pointer byte and then the word, high byte first. A write that stops after the pointer byte only moves the pointer, and a repeated START followed by a read turns it into a read from a chosen register. A read that starts straight after the address returns the word at the current pointer, high byte first. A word write reaches the register bank only when the closing STOP arrives. A clock-low watchdog abandons any transfer whose clock is held low too long and lets go of the data line.

Top module: `twi_regptr_slave`

## Requirements
- R1: The address byte is bits [7:4] = `0011`, bits [3:1] = `strap_i[2:0]`, bit [0] = direction (1 read, 0 write). A matching address is acknowledged by pulling SDA low in the 9th clock. On a mismatch SDA stays released, and every later byte is neither acknowledged nor acted on until the next START or STOP.
- R2: In a write, the slave acknowledges the pointer byte, the high data byte and the low data byte. At the closing STOP it gives exactly one `wr_stb_o` pulse, with `reg_addr_o` equal to the pointer and `wr_data_o` = {high byte, low byte}.
- R3: The pointer is 0x00 after reset. It changes only when a pointer byte is received from a matched write, and it keeps its value across transactions.
- R4: A read that follows the address directly shifts out the 16-bit word selected by the pointer, most significant bit first. SDA changes only after SCL falling edges. When the master answers the high byte with NACK, or after the low byte, SDA is released.
- R5: A write that carries only a pointer byte, followed by a repeated START and a read address, returns the word at the new pointer.
- R6: A repeated START that arrives before a STOP throws away a write word still waiting to be committed. The pointer from that transfer is kept.
- R7: With a pointer of 0x08 or above (for 8 registers), write bytes are still acknowledged but no `wr_stb_o` pulse occurs, and a read returns 0x0000 whatever `rd_data_i` holds.
- R8: If SCL stays low for TIMEOUT_CYC system cycles inside a transfer, the slave releases SDA, returns to idle and drops any pending write word. The count restarts on every SCL falling edge.
- R9: The slave changes its SDA drive only while SCL is low, apart from releasing it at a START, a STOP or a timeout.
- R10: Bytes sent after the low data byte of a write are not acknowledged. The word already received is still committed at STOP.
- R11: After reset SDA is released and neither `wr_stb_o` nor `rd_stb_o` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| strap_i | input | 3 | Low address bits from strap pins |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_addr_o | output | 8 | Current register pointer |
| rd_data_i | input | 16 | Word from the register bank at `reg_addr_o` |
| rd_stb_o | output | 1 | One-cycle pulse when a read word is captured |
| wr_stb_o | output | 1 | One-cycle pulse committing `wr_data_o` to `reg_addr_o` |
| wr_data_o | output | 16 | Word to be written |

## Verification
A table of pointer/word pairs is written and then read back twice: once through a selective read and once through an immediate read. This separates a failure in the commit path from a pointer that does not persist, and words with mixed, all-ones and all-zero bits expose swapped or shifted bytes. Wrong strap bits and a wrong preamble must draw no acknowledge and must leave the pointer alone, which separates address decoding from pointer handling. Directed cases cover:
- a repeated START in place of STOP;
- a surplus data byte;
- out-of-range pointers, read against a register model that returns a non-zero value there;
- a clock held low past the timeout, both while the slave is acknowledging and while a word is waiting for STOP.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned PRE_W   = BYTE_W - STRAP_W - 1;
  localparam logic [PRE_W-1:0] PREAMBLE = 4'b0011;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WHI,
    PH_WLO,
    PH_WEXTRA,
    PH_RSTART,
    PH_RHI,
    PH_RLO,
    PH_RDONE,
    PH_IGNORE
  } phase_t;

  // Address byte: preamble in the top bits, straps next, direction in bit 0.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [STRAP_W-1:0] strap);
    return (b[BYTE_W-1 -: PRE_W] == PREAMBLE) && (b[STRAP_W:1] == strap);
  endfunction

  function automatic logic ptr_in_range(input logic [BYTE_W-1:0] p,
                                        input int unsigned nreg);
    return {{(32-BYTE_W){1'b0}}, p} < nreg;
  endfunction

endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges while SCL is held high mark frame boundaries.
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_lowclk_timer.sv
module twi_lowclk_timer #(
  parameter int unsigned LIMIT = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic scl_fall_i,
  input  logic busy_i,
  output logic tmo_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!busy_i || scl_i || scl_fall_i) begin
      low_cnt <= '0;
    end else if (low_cnt != CW'(LIMIT)) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end

  assign tmo_o = busy_i & ~scl_i & (low_cnt == CW'(LIMIT));

  // R8: a timeout is only ever the end of a stretch of low clock
  a_r8_tmo_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> $past(!scl_i));

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_lvl_i,
  input  logic                sda_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                tmo_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [WORD_W-1:0]   rd_data_i,
  output logic                sda_pull_o,
  output logic [BYTE_W-1:0]   reg_addr_o,
  output logic                rd_stb_o,
  output logic                wr_stb_o,
  output logic [WORD_W-1:0]   wr_data_o,
  output logic                busy_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t              ph;
  logic [CNT_W-1:0]    bitcnt;
  logic [BYTE_W-1:0]   shreg, ptr, hi_q;
  logic [WORD_W-1:0]   wdata, txw, rd_word;
  logic                in_ack, oe, wr_pend, mack, wr_stb_q;

  // Named internal events
  logic rx_phase, tx_phase, bit_in, byte_in, ack_end, tx_load, ptr_ok, commit;

  assign rx_phase = (ph == PH_ADDR) || (ph == PH_PTR) || (ph == PH_WHI) ||
                    (ph == PH_WLO)  || (ph == PH_WEXTRA);
  assign tx_phase = (ph == PH_RHI) || (ph == PH_RLO);
  assign bit_in   = scl_rise_i & ~in_ack & rx_phase & (bitcnt != FULL);
  assign byte_in  = scl_fall_i & ~in_ack & rx_phase & (bitcnt == FULL);
  assign ack_end  = scl_fall_i & in_ack;
  assign tx_load  = ack_end & (ph == PH_RSTART);
  assign ptr_ok   = ptr_in_range(ptr, NREG);
  assign rd_word  = ptr_ok ? rd_data_i : '0;
  assign commit   = stop_i & wr_pend & ptr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      hi_q     <= '0;
      wdata    <= '0;
      txw      <= '0;
      in_ack   <= 1'b0;
      oe       <= 1'b0;
      wr_pend  <= 1'b0;
      mack     <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      wr_stb_q <= commit;
      if (tmo_i || start_i || stop_i) begin
        ph      <= start_i ? PH_ADDR : PH_IDLE;
        oe      <= 1'b0;
        in_ack  <= 1'b0;
        wr_pend <= 1'b0;
        bitcnt  <= '0;
      end else begin
        // receive direction
        if (bit_in) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_i};
          bitcnt <= bitcnt + CNT_W'(1);
        end
        if (byte_in) begin
          in_ack <= 1'b1;
          oe     <= 1'b1;
          unique case (ph)
            PH_ADDR: begin
              if (addr_hit(shreg, strap_i)) begin
                ph <= shreg[0] ? PH_RSTART : PH_PTR;
              end else begin
                ph     <= PH_IGNORE;
                oe     <= 1'b0;
                in_ack <= 1'b0;
              end
            end
            PH_PTR: begin
              ptr <= shreg;
              ph  <= PH_WHI;
            end
            PH_WHI: begin
              hi_q <= shreg;
              ph   <= PH_WLO;
            end
            PH_WLO: begin
              wdata   <= {hi_q, shreg};
              wr_pend <= 1'b1;
              ph      <= PH_WEXTRA;
            end
            default: oe <= 1'b0;
          endcase
        end
        // transmit direction
        if (tx_phase && !in_ack && scl_rise_i) begin
          bitcnt <= bitcnt + CNT_W'(1);
        end
        if (tx_phase && !in_ack && scl_fall_i) begin
          if (bitcnt == FULL) begin
            oe     <= 1'b0;
            in_ack <= 1'b1;
          end else begin
            txw <= {txw[WORD_W-2:0], 1'b0};
            oe  <= ~txw[WORD_W-2];
          end
        end
        if (in_ack && scl_rise_i) begin
          mack <= ~sda_i;
        end
        if (ack_end) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          oe     <= 1'b0;
          unique case (ph)
            PH_RSTART: begin
              txw <= rd_word;
              oe  <= ~rd_word[WORD_W-1];
              ph  <= PH_RHI;
            end
            PH_RHI: begin
              if (mack) begin
                txw <= {txw[WORD_W-2:0], 1'b0};
                oe  <= ~txw[WORD_W-2];
                ph  <= PH_RLO;
              end else begin
                ph <= PH_RDONE;
              end
            end
            PH_RLO:  ph <= PH_RDONE;
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_pull_o = oe;
  assign reg_addr_o = ptr;
  assign rd_stb_o   = tx_load;
  assign wr_stb_o   = wr_stb_q;
  assign wr_data_o  = wdata;
  assign busy_o     = (ph != PH_IDLE);

  // R9: drive changes only in the low half of the clock, or on a bus reset
  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> (!$past(scl_lvl_i) || $past(start_i || stop_i || tmo_i)));

  // R2: a commit pulse always comes right after a STOP
  a_r2_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(stop_i));

  // R7: nothing outside the register bank is ever written
  a_r7_commit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ptr_in_range(reg_addr_o, NREG));

  // R8: SDA released right after a timeout
  a_r8_release_on_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_i |=> !sda_pull_o);

  // R1: a slave that lost the address match stays silent
  a_r1_silent_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IGNORE) |-> !sda_pull_o);

endmodule

// File: rtl/twi_regptr_slave.sv
module twi_regptr_slave
  import twi_pkg::*;
#(
  parameter int unsigned NREG        = 8,
  parameter int unsigned TIMEOUT_CYC = 3000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  output logic        sda_pull_o,
  output logic [7:0]  reg_addr_o,
  input  logic [15:0] rd_data_i,
  output logic        rd_stb_o,
  output logic        wr_stb_o,
  output logic [15:0] wr_data_o
);

  logic scl_rise, scl_fall, start_evt, stop_evt, tmo_evt, busy;

  twi_line_monitor i_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  generate
    if (TIMEOUT_CYC > 0) begin : g_tmo
      twi_lowclk_timer #(.LIMIT(TIMEOUT_CYC)) i_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .scl_fall_i (scl_fall),
        .busy_i     (busy),
        .tmo_o      (tmo_evt)
      );
    end else begin : g_no_tmo
      assign tmo_evt = 1'b0;
    end
  endgenerate

  twi_slave_fsm #(.NREG(NREG)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (scl_i),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .tmo_i      (tmo_evt),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data_i),
    .sda_pull_o (sda_pull_o),
    .reg_addr_o (reg_addr_o),
    .rd_stb_o   (rd_stb_o),
    .wr_stb_o   (wr_stb_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy)
  );

endmodule

// File: tb/test_twi_regptr_slave.sv
module test_twi_regptr_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int TMO        = 200;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] PRE   = 4'b0011;
  localparam logic [23:0] VEC [0:5] = '{24'h00_1234, 24'h07_FFFF, 24'h03_8001,
                                        24'h05_0000, 24'h01_A5C3, 24'h07_0F0F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, rd_stb, wr_stb;
  logic [7:0]  reg_addr;
  logic [15:0] rd_data, wr_data;
  wire  sda_line = sda_m & ~sda_pull;

  logic [15:0] rf [8];
  logic [15:0] exp_rf [8];
  int n_cmp = 0, n_bad = 0, stb_cnt = 0, unstable = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_regptr_slave #(.NREG(8), .TIMEOUT_CYC(TMO)) i_twi_regptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .sda_pull_o(sda_pull), .reg_addr_o(reg_addr), .rd_data_i(rd_data),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .wr_data_o(wr_data));

  // Peer register bank; out-of-range pointers see a non-zero value.
  assign rd_data = (reg_addr < 8'd8) ? rf[reg_addr[2:0]] : 16'hDEAD;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 16'h5A00 + 16'(i);
    end else if (wr_stb) begin
      rf[reg_addr[2:0]] <= wr_data;
      stb_cnt <= stb_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(1);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line; tick(Q/2); scl_m = 1'b0; tick(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(1); s1 = sda_line; tick(Q-2);
      b[i] = sda_line;
      if (s1 !== b[i]) unstable++;
      tick(1); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic wr_word(input logic [7:0] p, input logic [15:0] d, input string req);
    logic a0, a1, a2, a3;
    bus_start();
    send_byte({PRE, STRAP, 1'b0}, a0);
    send_byte(p, a1);
    send_byte(d[15:8], a2);
    send_byte(d[7:0], a3);
    bus_stop();
    chk(req, {12'd0, a0, a1, a2, a3}, 16'h000F);
    if (p < 8'd8) exp_rf[p[2:0]] = d;
  endtask

  task automatic rd_tail(output logic [15:0] d);
    logic a;
    logic [7:0] hi, lo;
    send_byte({PRE, STRAP, 1'b1}, a);
    recv_byte(1'b1, hi);
    recv_byte(1'b0, lo);
    bus_stop();
    d = {hi, lo};
  endtask

  task automatic rd_sel(input logic [7:0] p, output logic [15:0] d);
    logic a0, a1;
    bus_start();
    send_byte({PRE, STRAP, 1'b0}, a0);
    send_byte(p, a1);
    bus_start();
    rd_tail(d);
  endtask

  task automatic rd_imm(output logic [15:0] d);
    bus_start();
    rd_tail(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic a, a2;
    int s0;
    for (int i = 0; i < 8; i++) exp_rf[i] = 16'h5A00 + 16'(i);
    tick(5); rst_n = 1'b1; tick(3);

    // R11 reset state; R3 pointer starts at 0
    chk("R11 sda", {15'd0, sda_pull}, 16'd0);
    chk("R11 strobes", {14'd0, wr_stb, rd_stb}, 16'd0);
    chk("R3 reset ptr", {8'd0, reg_addr}, 16'd0);
    rd_imm(d);
    chk("R4 read at reset ptr", d, exp_rf[0]);

    // table walk: R2 write, R5 selective read, R3 pointer persistence
    for (int v = 0; v < 6; v++) begin
      s0 = stb_cnt;
      wr_word(VEC[v][23:16], VEC[v][15:0], "R2 acks");
      chk("R2 one strobe", 16'(stb_cnt - s0), 16'd1);
      rd_sel(VEC[v][23:16], d);
      chk("R5 selective read", d, VEC[v][15:0]);
      rd_imm(d);
      chk("R3 pointer kept", d, VEC[v][15:0]);
    end

    // R7 out-of-range pointer
    s0 = stb_cnt;
    wr_word(8'h08, 16'hBEEF, "R7 acks");
    chk("R7 no strobe", 16'(stb_cnt - s0), 16'd0);
    rd_sel(8'h08, d);
    chk("R7 read zero 08", d, 16'h0000);
    rd_sel(8'hFF, d);
    chk("R7 read zero FF", d, 16'h0000);

    // R1 mismatch: wrong straps then wrong preamble, pointer untouched
    rd_sel(8'h01, d);
    bus_start();
    send_byte({PRE, 3'b010, 1'b0}, a);
    send_byte(8'h02, a2);
    bus_stop();
    chk("R1 strap mismatch", {14'd0, a, a2}, 16'd0);
    bus_start();
    send_byte({4'b0111, STRAP, 1'b1}, a);
    bus_stop();
    chk("R1 preamble mismatch", {15'd0, a}, 16'd0);
    rd_imm(d);
    chk("R1 ignored ptr byte", d, exp_rf[1]);

    // R6 repeated START discards pending word
    s0 = stb_cnt;
    bus_start();
    send_byte({PRE, STRAP, 1'b0}, a);
    send_byte(8'h03, a);
    send_byte(8'hAA, a);
    send_byte(8'h55, a);
    bus_start();
    rd_tail(d);
    chk("R6 old value", d, exp_rf[3]);
    chk("R6 no strobe", 16'(stb_cnt - s0), 16'd0);

    // R10 surplus byte NACKed, word still committed
    bus_start();
    send_byte({PRE, STRAP, 1'b0}, a);
    send_byte(8'h06, a);
    send_byte(8'h13, a);
    send_byte(8'h57, a);
    send_byte(8'h99, a2);
    bus_stop();
    exp_rf[6] = 16'h1357;
    chk("R10 extra nack", {15'd0, a2}, 16'd0);
    rd_sel(8'h06, d);
    chk("R10 committed", d, 16'h1357);

    // R8 timeout while acknowledging the address
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = (i >= 4) ? PRE[i-4] : ((i >= 1) ? STRAP[i-1] : 1'b0);
      tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(1);
    end
    sda_m = 1'b1; tick(Q);
    chk("R1 ack driven", {15'd0, sda_line}, 16'd0);
    tick(TMO + 20);
    chk("R8 released", {15'd0, sda_line}, 16'd1);
    scl_m = 1'b1; tick(Q); bus_stop();

    // R8 timeout drops a pending word
    s0 = stb_cnt;
    bus_start();
    send_byte({PRE, STRAP, 1'b0}, a);
    send_byte(8'h04, a);
    send_byte(8'hC3, a);
    send_byte(8'h3C, a);
    tick(TMO + 20);
    bus_stop();
    chk("R8 no strobe", 16'(stb_cnt - s0), 16'd0);
    rd_sel(8'h04, d);
    chk("R8 old value kept", d, exp_rf[4]);

    // R9 read bits stayed stable through every SCL high phase
    chk("R9 stable data", 16'(unstable), 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule